// File: doc/BRIEF.md
# One-Bit Audio Stream Validity Monitor

This block watches a single-bit delta-sigma audio stream. The stream arrives one bit at a time, and each bit is qualified by a strobe on the system clock. The block runs two independent checks on the stream:

- **Stall check.** It reports a stall when the stream holds one level for a full run of 28 bits. The result is a mute request.
- **Bias check.** It reports a bias when the most recent 28 bits lean heavily toward one value. The result is an attenuate request.

Each request is a level flag for downstream mute and attenuation logic. Each check has its own enable bit in a small control register that has a simple write port. Two further control bits are stored only, for the phase-modulation input path, and have no effect inside this block.

The condition behind each flag is tracked on every bit strobe, whether or not its check is enabled. The enable bit only gates the output. Clearing an enable therefore drops its flag on the same edge as the register write.

Top module: `bsm_top`

## Requirements
- R1: After a synchronous reset, `cfg_rdata` reads 0x08, and both `mute_req` and `atten_req` are low.
- R2: A write through `cfg_we` stores bits 3..0 of `cfg_wdata`, and bits 7..4 always read as 0. Bit 3 enables the stall check and bit 2 enables the bias check. Bits 1 and 0 are stored but change neither flag.
- R3: With bit 3 set, `mute_req` is high in the cycle after the strobe that completes 28 consecutive equal bits, whether the bits are all 0 or all 1.
- R4: A run of 27 equal bits followed by a differing bit never raises `mute_req`.
- R5: With bit 2 set and at least 28 bits received, `atten_req` is high exactly when the last 28 bits hold more than 24 ones or fewer than 4 ones. Windows with exactly 24 ones or exactly 4 ones do not raise it.
- R6: `atten_req` stays low until at least 28 bits have been strobed in since reset.
- R7: When a check's enable bit is 0, its flag is low. A write that clears the bit drops the flag in the cycle after the write.
- R8: Clock cycles without `bit_vld` change neither flag nor the stored history.
- R9: Each flag clears in the cycle after the first strobe at which its condition no longer holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe that qualifies `bit_in` |
| bit_in | input | 1 | Stream bit |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| mute_req | output | 1 | Stall (mute) request |
| atten_req | output | 1 | Bias (attenuate) request |

## Verification
The hardest situation to reach from the ports is a bias window sitting exactly on a threshold: exactly 24, 25, 4 or 3 ones among the last 28 bits, held across many successive windows. Random streams almost never produce this.

The stimulus drives periodic patterns with a period of 28 bits that place exactly k ones in each period. Every sliding window then holds exactly k ones, so each boundary is exercised over many shifts.

Runs of 27 and 28 equal bits exercise the stall edge. Runs interleaved with idle strobe cycles and enable writes exercise the idle-cycle and gating behaviour.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    localparam int          CFG_W        = 8;
    localparam int          STALL_EN_BIT = 3;
    localparam int          BIAS_EN_BIT  = 2;
    localparam logic [7:0]  CFG_RESET    = 8'h08;
    localparam logic [7:0]  CFG_MASK     = 8'h0F;
endpackage

// File: rtl/bsm_cfg_reg.sv
module bsm_cfg_reg
    import bsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) s_d.cfg = wdata & CFG_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.cfg <= CFG_RESET;
        else     s_q     <= s_d;
    end

    assign rdata = s_q.cfg;

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~CFG_MASK) == '0);

    // R2
    hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(we) && !$past(rst) |-> $stable(rdata));
endmodule

// File: rtl/bsm_run_det.sv
module bsm_run_det #(
    parameter int RUN_LEN = 28
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic stall
);
    localparam int CW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          last;
        logic          cond;
    } run_state_t;

    run_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (bit_vld) begin
            s_d.last = bit_in;
            if (s_q.run == '0 || bit_in != s_q.last)
                s_d.run = CW'(1);
            else if (s_q.run < CW'(RUN_LEN))
                s_d.run = s_q.run + CW'(1);
            s_d.cond = (s_d.run == CW'(RUN_LEN));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign stall = s_q.cond;

    // R3
    run_sat_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.run <= CW'(RUN_LEN));

    // R8
    stall_rise_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> $past(bit_vld));
endmodule

// File: rtl/bsm_bias_det.sv
module bsm_bias_det #(
    parameter int WIN    = 28,
    parameter int HI_THR = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic bias
);
    localparam int CW     = $clog2(WIN + 1);
    localparam int LO_THR = WIN - HI_THR;

    typedef struct packed {
        logic [WIN-1:0] win;
        logic [CW-1:0]  ones;
        logic [CW-1:0]  fill;
        logic           cond;
    } bias_state_t;

    bias_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (bit_vld) begin
            s_d.win  = {s_q.win[WIN-2:0], bit_in};
            s_d.ones = s_q.ones + CW'(bit_in) - CW'(s_q.win[WIN-1]);
            if (s_q.fill < CW'(WIN)) s_d.fill = s_q.fill + CW'(1);
            s_d.cond = (s_d.fill == CW'(WIN)) &&
                       ((s_d.ones > CW'(HI_THR)) || (s_d.ones < CW'(LO_THR)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign bias = s_q.cond;

    // R5
    ones_range_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.ones <= CW'(WIN) && s_q.ones <= s_q.fill);

    // R6
    bias_needs_fill_chk: assert property (@(posedge clk) disable iff (rst)
        bias |-> s_q.fill == CW'(WIN));

    // R8
    bias_rise_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bias) |-> $past(bit_vld));
endmodule

// File: rtl/bsm_top.sv
module bsm_top
    import bsm_pkg::*;
#(
    parameter int RUN_LEN = 28,
    parameter int WIN     = 28,
    parameter int HI_THR  = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       mute_req,
    output logic       atten_req
);
    logic stall_c, bias_c;

    bsm_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata)
    );

    bsm_run_det #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .stall   (stall_c)
    );

    bsm_bias_det #(.WIN(WIN), .HI_THR(HI_THR)) u_bias (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .bias    (bias_c)
    );

    assign mute_req  = stall_c & cfg_rdata[STALL_EN_BIT];
    assign atten_req = bias_c  & cfg_rdata[BIAS_EN_BIT];
endmodule

// File: tb/bsm_top_tb_top.sv
`timescale 1ns/1ps
module bsm_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       mute_req, atten_req;

    always #10 clk = ~clk;

    bsm_top dut_i (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mute_req(mute_req), .atten_req(atten_req)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit hist[$];
    bit stall_m = 0, bias_m = 0;
    logic [7:0] reg_m = 8'h08;

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void model(bit r, bit v, bit b, bit we, logic [7:0] wd);
        int ones;
        if (r) begin
            hist.delete(); stall_m = 0; bias_m = 0; reg_m = 8'h08;
            return;
        end
        if (we) reg_m = wd & 8'h0F;
        if (v) begin
            hist.push_back(b);
            if (hist.size() > 28) void'(hist.pop_front());
            ones = 0;
            foreach (hist[i]) ones += hist[i];
            stall_m = (hist.size() == 28) && (ones == 0 || ones == 28);
            bias_m  = (hist.size() == 28) && (ones > 24 || ones < 4);
        end
    endfunction

    task automatic step(string tag, bit r, bit v, bit b, bit we, logic [7:0] wd);
        rst = r; bit_vld = v; bit_in = b; cfg_we = we; cfg_wdata = wd;
        model(r, v, b, we, wd);
        @(posedge clk);
        @(negedge clk);
        check(tag, "cfg_rdata", cfg_rdata, reg_m);
        check(tag, "mute_req", {7'b0, mute_req}, {7'b0, stall_m & reg_m[3]});
        check(tag, "atten_req", {7'b0, atten_req}, {7'b0, bias_m & reg_m[2]});
    endtask

    task automatic bits(string tag, int n, bit b);
        for (int i = 0; i < n; i++) step(tag, 0, 1, b, 0, 8'h00);
    endtask

    task automatic wr(string tag, logic [7:0] d);
        step(tag, 0, 0, 0, 1, d);
    endtask

    // period-28 pattern holding exactly k ones in every window
    task automatic periodic(string tag, int k, int n);
        for (int i = 0; i < n; i++) step(tag, 0, 1, (i % 28) < k, 0, 8'h00);
    endtask

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        step("R1", 1, 0, 0, 0, 8'h00);
        step("R1", 1, 0, 0, 0, 8'h00);
        step("R1", 0, 0, 0, 0, 8'h00);
        // R2: reserved bits dropped, both checks enabled, bits 1..0 inert
        wr("R2", 8'hFF);
        // R6: 27 zeros, window not yet full
        bits("R6", 27, 0);
        // R3 / R5: 28th zero raises both
        bits("R3", 1, 0);
        // R9: differing bit clears mute; bias stays (1 one < 4)
        bits("R9", 1, 1);
        // R8: idle cycles
        for (int i = 0; i < 5; i++) step("R8", 0, 0, 1, 0, 8'h00);
        // R4: run of 27 ones then a zero
        bits("R4", 26, 1);
        bits("R4", 1, 0);
        // R3: 28 ones
        bits("R3", 28, 1);
        for (int i = 0; i < 3; i++) step("R8", 0, 0, 0, 0, 8'h00);
        // R7: clear stall enable, then bias enable
        wr("R7", 8'h04);
        bits("R7", 2, 1);
        wr("R7", 8'h00);
        wr("R7", 8'h0C);
        // R5: thresholds
        periodic("R5", 24, 84);
        periodic("R5", 25, 84);
        periodic("R5", 4, 84);
        periodic("R5", 3, 84);
        periodic("R5", 28, 40);
        // R2: bits 1..0 toggled leave flags unchanged
        wr("R2", 8'h0D);
        wr("R2", 8'h0E);
        wr("R2", 8'h0C);
        // R9: mixed random traffic with occasional writes and idle cycles
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 100;
            int bias_k = ((i / 300) % 2) ? 2 : 95;
            if (r < 3)
                step("R9", 0, 0, 0, 1, 8'($urandom));
            else
                step("R9", 0, (r % 4) != 0, ($urandom % 100) < bias_k, 0, 8'h00);
        end
        // R1: reset mid-stream
        step("R1", 1, 1, 1, 0, 8'h00);
        step("R6", 0, 1, 1, 0, 8'h00);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule